// File: doc/BRIEF.md
# Synthesizer Feedback and Reference Dividers

This block holds the two counting dividers of a PLL frequency synthesizer and delivers their outputs to a phase detector. The feedback divider counts edges from one of two oscillator inputs. Each edge arrives as a single-cycle enable in the system clock domain. A 16-bit divide word and two mode bits set the ratio, the input source and the position of the least significant bit. The reference divider counts crystal ticks, which nominally arrive at 75 kHz. It turns them into a comparison rate chosen by a 4-bit rate code.

Every terminal count gives a one-cycle pulse and reloads the counter from the settings present at that moment. Two of the rate codes stop the whole synthesizer. While one of them is set, both counters are held cleared and no pulse leaves the block. An inhibit flag tells the charge pump to go high-impedance. A second flag, raised by one of the two codes only, tells the crystal oscillator to stop.

Top module: `synth_dividers`

## Requirements
- R1: While rst_ni is low, ref_pulse_o and fb_pulse_o are 0. After reset both counters are cleared, so the first counted event gives a pulse.
- R2: The reference ratio in crystal ticks is set by ref_code_i: 0000, 0001, 0010 and 0011 give 3; 0100 gives 6; 0101 gives 12; 0110 and 0111 give 24; 1000, 1001 and 1010 give 15; 1011 gives 75; 1100 gives 25; 1101 gives 5.
- R3: Codes 1110 and 1111 drive inhibit_o to 1 and all other codes drive it to 0. Only code 1110 drives osc_stop_o to 1. While inhibit_o is 1, both counters are held cleared and neither pulse output goes high in the following cycle.
- R4: With fm_sel_i=1, the feedback divider counts only fm_edge_i and divides by twice N. N is div_word_i[15:0]. am_edge_i has no effect.
- R5: With fm_sel_i=0 and am_hi_i=1, the feedback divider counts only am_edge_i and divides by N = div_word_i[15:0]. fm_edge_i has no effect.
- R6: With fm_sel_i=0 and am_hi_i=0, the feedback divider counts am_edge_i and divides by N = div_word_i[15:4]. Bits 3..0 have no effect.
- R7: A value of N below its mode's minimum is raised to that minimum. The minimum is 272 in the modes of R4 and R5 and 4 in the mode of R6.
- R8: Each pulse lasts one cycle. After the first pulse from a cleared state, each further pulse comes on every ratio-th counted event.
- R9: A change of divide word, mode or rate code takes effect at the next reload. The period that is already running completes with the old ratio.
- R10: A pulse is visible in the clock cycle that follows the cycle in which its counted event was present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xtal_tick_i | input | 1 | One-cycle enable per crystal period |
| fm_edge_i | input | 1 | One-cycle enable per FM oscillator edge |
| am_edge_i | input | 1 | One-cycle enable per AM oscillator edge |
| fm_sel_i | input | 1 | 1: FM source with doubled ratio |
| am_hi_i | input | 1 | AM range select: 1 uses the full word, 0 uses the upper 12 bits |
| div_word_i | input | 16 | Feedback divide word |
| ref_code_i | input | 4 | Reference rate code |
| ref_pulse_o | output | 1 | Reference divider terminal-count pulse |
| fb_pulse_o | output | 1 | Feedback divider terminal-count pulse |
| inhibit_o | output | 1 | Synthesizer stopped, charge pump high-impedance |
| osc_stop_o | output | 1 | Crystal oscillator stop request |

## Verification
If a counter holds a wrong count, the pulse after the current one comes early or late. This shows up within one ratio of counted events, which is at most 75 ticks for the reference divider and a few hundred edges for the feedback divider in the ranges the bench uses. If a ratio is latched at the wrong time, or a clear is missed when the synthesizer is stopped, the spacing of pulses after a setting change or after an inhibit period is wrong. The bench compares each output in every cycle with a model of the count, so the first misplaced or missing pulse is reported in the cycle where it happens.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;
  localparam int unsigned REF_CODE_W = 4;
  localparam int unsigned REF_CNT_W  = 7;

  typedef enum logic [1:0] {
    FB_FM_X2    = 2'd0,
    FB_AM_WIDE  = 2'd1,
    FB_AM_NARROW = 2'd2
  } fb_mode_e;

  function automatic logic [REF_CNT_W-1:0] ref_ratio(input logic [REF_CODE_W-1:0] code);
    logic [REF_CNT_W-1:0] r;
    unique casez (code)
      4'b00??:                    r = 7'd3;
      4'b0100:                    r = 7'd6;
      4'b0101:                    r = 7'd12;
      4'b011?:                    r = 7'd24;
      4'b1000, 4'b1001, 4'b1010:  r = 7'd15;
      4'b1011:                    r = 7'd75;
      4'b1100:                    r = 7'd25;
      4'b1101:                    r = 7'd5;
      default:                    r = 7'd3; // inhibit codes, counter held anyway
    endcase
    return r;
  endfunction
endpackage

// File: rtl/div_counter.sv
module div_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             pulse_o
);
  logic [CNT_W-1:0] cnt_q;

  // Cleared counter pulses on the first event, then reloads ratio-1.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (en_i) begin
        if (cnt_q == '0) begin
          pulse_o <= 1'b1;
          cnt_q   <= ratio_i - 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ref_rate_sel.sv
module ref_rate_sel
  import synth_div_pkg::*;
(
  input  logic [REF_CODE_W-1:0] code_i,
  output logic [REF_CNT_W-1:0]  ratio_o,
  output logic                  inhibit_o,
  output logic                  osc_stop_o
);
  always_comb begin
    ratio_o    = ref_ratio(code_i);
    inhibit_o  = (code_i[REF_CODE_W-1:1] == 3'b111);
    osc_stop_o = (code_i == 4'b1110);
  end
endmodule

// File: rtl/fb_ratio_calc.sv
module fb_ratio_calc
  import synth_div_pkg::*;
#(
  parameter int unsigned DIV_W        = 16,
  parameter int unsigned NARROW_SHIFT = 4,
  parameter int unsigned MIN_WIDE     = 272,
  parameter int unsigned MIN_NARROW   = 4
) (
  input  logic [DIV_W-1:0] word_i,
  input  logic             fm_sel_i,
  input  logic             am_hi_i,
  output logic [DIV_W:0]   ratio_o
);
  fb_mode_e         mode;
  logic [DIV_W-1:0] base, floor_v, n;

  always_comb begin
    if (fm_sel_i)     mode = FB_FM_X2;
    else if (am_hi_i) mode = FB_AM_WIDE;
    else              mode = FB_AM_NARROW;

    if (mode == FB_AM_NARROW) begin
      base    = word_i >> NARROW_SHIFT;
      floor_v = DIV_W'(MIN_NARROW);
    end else begin
      base    = word_i;
      floor_v = DIV_W'(MIN_WIDE);
    end
    n = (base < floor_v) ? floor_v : base;
    ratio_o = (mode == FB_FM_X2) ? {n, 1'b0} : {1'b0, n};
  end
endmodule

// File: rtl/synth_dividers.sv
module synth_dividers
  import synth_div_pkg::*;
#(
  parameter int unsigned DIV_W        = 16,
  parameter int unsigned NARROW_SHIFT = 4,
  parameter int unsigned MIN_WIDE     = 272,
  parameter int unsigned MIN_NARROW   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  xtal_tick_i,
  input  logic                  fm_edge_i,
  input  logic                  am_edge_i,
  input  logic                  fm_sel_i,
  input  logic                  am_hi_i,
  input  logic [DIV_W-1:0]      div_word_i,
  input  logic [REF_CODE_W-1:0] ref_code_i,
  output logic                  ref_pulse_o,
  output logic                  fb_pulse_o,
  output logic                  inhibit_o,
  output logic                  osc_stop_o
);
  localparam int unsigned FB_CNT_W = DIV_W + 1;

  logic [REF_CNT_W-1:0] ref_ratio_w;
  logic [FB_CNT_W-1:0]  fb_ratio_w;
  logic                 fb_edge;

  ref_rate_sel u_rate (
    .code_i     (ref_code_i),
    .ratio_o    (ref_ratio_w),
    .inhibit_o  (inhibit_o),
    .osc_stop_o (osc_stop_o)
  );

  fb_ratio_calc #(
    .DIV_W        (DIV_W),
    .NARROW_SHIFT (NARROW_SHIFT),
    .MIN_WIDE     (MIN_WIDE),
    .MIN_NARROW   (MIN_NARROW)
  ) u_fbr (
    .word_i   (div_word_i),
    .fm_sel_i (fm_sel_i),
    .am_hi_i  (am_hi_i),
    .ratio_o  (fb_ratio_w)
  );

  assign fb_edge = fm_sel_i ? fm_edge_i : am_edge_i;

  div_counter #(.CNT_W(REF_CNT_W)) u_ref_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (inhibit_o),
    .en_i    (xtal_tick_i),
    .ratio_i (ref_ratio_w),
    .pulse_o (ref_pulse_o)
  );

  div_counter #(.CNT_W(FB_CNT_W)) u_fb_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (inhibit_o),
    .en_i    (fb_edge),
    .ratio_i (fb_ratio_w),
    .pulse_o (fb_pulse_o)
  );
endmodule

// File: rtl/synth_dividers_chk.sv
module synth_dividers_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       xtal_tick_i,
  input logic       fm_edge_i,
  input logic       am_edge_i,
  input logic       fm_sel_i,
  input logic [3:0] ref_code_i,
  input logic       ref_pulse_o,
  input logic       fb_pulse_o,
  input logic       inhibit_o,
  input logic       osc_stop_o
);
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!ref_pulse_o && !fb_pulse_o));

  p_inhibit_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(inhibit_o) |-> (!ref_pulse_o && !fb_pulse_o));

  p_osc_stop_inh_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_stop_o |-> (inhibit_o && ref_code_i[0] == 1'b0));

  p_ref_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pulse_o |=> !ref_pulse_o);

  p_fb_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |=> !fb_pulse_o);

  p_ref_after_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pulse_o |-> $past(xtal_tick_i));

  p_fb_after_edge_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |-> ($past(fm_sel_i) ? $past(fm_edge_i) : $past(am_edge_i)));
endmodule

bind synth_dividers synth_dividers_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .xtal_tick_i (xtal_tick_i),
  .fm_edge_i   (fm_edge_i),
  .am_edge_i   (am_edge_i),
  .fm_sel_i    (fm_sel_i),
  .ref_code_i  (ref_code_i),
  .ref_pulse_o (ref_pulse_o),
  .fb_pulse_o  (fb_pulse_o),
  .inhibit_o   (inhibit_o),
  .osc_stop_o  (osc_stop_o)
);

// File: tb/sim_synth_dividers.sv
module sim_synth_dividers;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xtal_tick_i = 1'b0, fm_edge_i = 1'b0, am_edge_i = 1'b0;
  logic        fm_sel_i = 1'b0, am_hi_i = 1'b1;
  logic [15:0] div_word_i = 16'd300;
  logic [3:0]  ref_code_i = 4'd0;
  logic        ref_pulse_o, fb_pulse_o, inhibit_o, osc_stop_o;

  int checks = 0, fails = 0;
  int ref_left = 0, fb_left = 0;
  int ref_seen = 0, fb_seen = 0;

  always #2 clk_i = ~clk_i;

  synth_dividers u0 (.*);

  function automatic int exp_ref_ratio(input logic [3:0] c);
    case (c)
      4'd0, 4'd1, 4'd2, 4'd3: return 3;
      4'd4: return 6;
      4'd5: return 12;
      4'd6, 4'd7: return 24;
      4'd8, 4'd9, 4'd10: return 15;
      4'd11: return 75;
      4'd12: return 25;
      4'd13: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_fb_ratio(input logic fm, input logic hi, input logic [15:0] w);
    int n;
    if (fm || hi) begin
      n = (w < 272) ? 272 : int'(w);
      return fm ? 2 * n : n;
    end
    n = int'(w[15:4]);
    return (n < 4) ? 4 : n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Inputs are set at the falling edge; outputs are compared at the next falling edge.
  task automatic step(input logic xt, input logic fe, input logic ae);
    bit inh, er, ef, fbe;
    xtal_tick_i = xt; fm_edge_i = fe; am_edge_i = ae;
    inh = (ref_code_i >= 4'd14);
    fbe = fm_sel_i ? fe : ae;
    er = xt && !inh && ref_left == 0;
    ef = fbe && !inh && fb_left == 0;
    if (inh) begin
      ref_left = 0; fb_left = 0;
    end else begin
      if (xt) ref_left = (ref_left == 0) ? exp_ref_ratio(ref_code_i) - 1 : ref_left - 1;
      if (fbe) fb_left = (fb_left == 0) ? exp_fb_ratio(fm_sel_i, am_hi_i, div_word_i) - 1 : fb_left - 1;
    end
    #1;
    chk("R3 inhibit flag", int'(inhibit_o), int'(inh));
    chk("R3 osc stop flag", int'(osc_stop_o), int'(ref_code_i == 4'd14));
    @(negedge clk_i);
    chk("R2 R8 R10 ref pulse", int'(ref_pulse_o), int'(er));
    chk("R4 R5 R6 R7 R9 fb pulse", int'(fb_pulse_o), int'(ef));
    ref_seen += int'(ref_pulse_o);
    fb_seen += int'(fb_pulse_o);
  endtask

  task automatic run(input int n, input logic xt, input logic fe, input logic ae);
    for (int i = 0; i < n; i++) step(xt, fe, ae);
  endtask

  task automatic clear_state();
    logic [3:0] keep;
    keep = ref_code_i;
    ref_code_i = 4'b1111;
    step(1'b1, 1'b1, 1'b1);
    ref_code_i = keep;
    ref_seen = 0; fb_seen = 0;
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #1;
    @(negedge clk_i);
    chk("R1 ref pulse in reset", int'(ref_pulse_o), 0);
    chk("R1 fb pulse in reset", int'(fb_pulse_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: first counted event after reset pulses at once
    step(1'b1, 1'b0, 1'b1);
    chk("R1 first ref pulse", ref_seen, 1);
    chk("R1 first fb pulse", fb_seen, 1);

    // R2: ratio 75 over 151 ticks from cleared state gives 3 pulses
    ref_code_i = 4'b1011; clear_state();
    run(151, 1'b1, 1'b0, 1'b0);
    chk("R2 ratio 75 pulse count", ref_seen, 3);

    // R3: both inhibit codes silence the outputs
    ref_code_i = 4'b1110; ref_seen = 0; fb_seen = 0;
    run(40, 1'b1, 1'b1, 1'b1);
    chk("R3 code 1110 silent", ref_seen + fb_seen, 0);
    ref_code_i = 4'b1111;
    run(40, 1'b1, 1'b1, 1'b1);
    chk("R3 code 1111 silent", ref_seen + fb_seen, 0);
    ref_code_i = 4'b0000;

    // R4: FM source, AM edges ignored
    fm_sel_i = 1'b1; div_word_i = 16'd300; clear_state();
    run(700, 1'b0, 1'b0, 1'b1);
    chk("R4 am edges ignored", fb_seen, 0);
    clear_state();
    run(601, 1'b0, 1'b1, 1'b0);
    chk("R4 doubled ratio 600", fb_seen, 2);

    // R5: AM wide source, FM edges ignored
    fm_sel_i = 1'b0; am_hi_i = 1'b1; clear_state();
    run(400, 1'b0, 1'b1, 1'b0);
    chk("R5 fm edges ignored", fb_seen, 0);
    clear_state();
    run(301, 1'b0, 1'b0, 1'b1);
    chk("R5 ratio 300", fb_seen, 2);

    // R6: narrow mode, low nibble ignored
    am_hi_i = 1'b0; div_word_i = 16'h005F; clear_state();
    run(20, 1'b0, 1'b0, 1'b1);
    chk("R6 word 005F ratio 5", fb_seen, 4);

    // R7: clamps
    div_word_i = 16'h0035; clear_state();
    run(9, 1'b0, 1'b0, 1'b1);
    chk("R7 narrow clamp to 4", fb_seen, 3);
    am_hi_i = 1'b1; div_word_i = 16'd10; clear_state();
    run(545, 1'b0, 1'b0, 1'b1);
    chk("R7 wide clamp to 272", fb_seen, 3);

    // R9: a new word waits for the reload
    am_hi_i = 1'b0; div_word_i = 16'h00A0; clear_state();
    step(1'b0, 1'b0, 1'b1);
    div_word_i = 16'h0060; fb_seen = 0;
    run(9, 1'b0, 1'b0, 1'b1);
    chk("R9 old period still running", fb_seen, 0);
    run(1, 1'b0, 1'b0, 1'b1);
    chk("R9 old period completes", fb_seen, 1);
    run(6, 1'b0, 1'b0, 1'b1);
    chk("R9 new ratio 6 applied", fb_seen, 2);

    // Random segments, every cycle checked against the model
    for (int s = 0; s < 40; s++) begin
      int len;
      fm_sel_i = 1'($urandom_range(0, 1));
      am_hi_i = 1'($urandom_range(0, 1));
      if (fm_sel_i || am_hi_i) div_word_i = 16'($urandom_range(0, 620));
      else div_word_i = 16'($urandom_range(0, 1000));
      ref_code_i = 4'($urandom_range(0, 15));
      len = $urandom_range(50, 1500);
      for (int i = 0; i < len; i++)
        step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule